// File: doc/BRIEF.md
# Shared D-Channel Transmit Gate with Collision Retry

This block decides when bytes of a frame may go out on a D channel that several terminals share. A layer-1 device watches the shared bus and reports whether the channel is free. It can report this in one of two ways. The first is bit 4 of a command/indication code that arrives each frame. That bit is low when the channel is free and high when it is busy or a collision has been seen. The second is a separate grant line, which is high when the channel is free. A mode input selects which of the two indications the gate uses.

A frame is a run of bytes held in an external store. The gate addresses the store through a read pointer that counts from the start of the frame and takes the byte back in the same cycle. Whenever the channel is free and the transmit slot input is high, the gate passes one byte out. A collision may come while one of the first two buffers of the frame is going out, a buffer being BUF_BYTES bytes. In that case the gate abandons the attempt, rewinds to byte 0, counts a retry and starts again as soon as the channel is free. If the collision comes later in the frame, the gate gives up on the frame and raises an error pulse.

The retry counter is visible on a port. It saturates at its maximum value, and it is cleared when a frame completes.

Top module: `dchan_tx_gate`

## Requirements
- R1: After reset the gate is idle: busy, tx_en, done and err are 0, rd_ptr is 0 and retries is 0.
- R2: No byte is transmitted (tx_en stays 0) while the selected free indication reports busy. With use_grant=0 this means ci_code bit 4 is 1. With use_grant=1 this means grant is 0.
- R3: While sending with the channel free, each cycle with slot=1 transmits one byte: tx_en=1, tx_byte equals rd_data, and rd_ptr advances by one at the next edge. A cycle with slot=0 transmits nothing and leaves rd_ptr unchanged.
- R4: A collision while rd_ptr is below 2*BUF_BYTES suppresses tx_en in that cycle. In the next cycle rd_ptr is 0 and retries is one higher. The frame is then sent again from byte 0 once the channel is free.
- R5: A collision while rd_ptr is 2*BUF_BYTES or more ends the frame. err pulses high for one cycle in the next cycle, busy falls, and retries keeps its value.
- R6: After the byte at rd_ptr = frame_len-1 is sent, done pulses high for one cycle in the next cycle, busy falls and retries reads 0.
- R7: With use_grant=1, ci_code has no effect and grant high means free. With use_grant=0, grant has no effect.
- R8: A start pulse is ignored while the gate is busy, and it is also ignored when frame_len is 0. A frame, once started, keeps the length latched at its start.
- R9: retries saturates at its all-ones value and does not wrap, however many further early collisions occur.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ci_code | input | CI_W | Command/indication code from layer 1; bit 4 high means busy or collision |
| grant | input | 1 | Alternative free indication, high means free |
| use_grant | input | 1 | 1 selects grant, 0 selects ci_code bit 4 |
| start | input | 1 | Request to send a frame of frame_len bytes |
| frame_len | input | LEN_W | Frame length in bytes, 0 is rejected |
| slot | input | 1 | Transmit opportunity for one byte this cycle |
| rd_data | input | 8 | Byte at rd_ptr from the frame store |
| rd_ptr | output | LEN_W | Byte index within the frame being read |
| tx_en | output | 1 | A byte is transmitted this cycle |
| tx_byte | output | 8 | Byte transmitted |
| busy | output | 1 | A frame is in progress |
| done | output | 1 | One-cycle pulse: frame completed |
| err | output | 1 | One-cycle pulse: frame ended by a late collision |
| retries | output | RETRY_W | Retries since the last completed frame |

## Verification
The main sweep sends every frame length from 1 to 9 bytes. For each length it runs once with no collision and once with a single collision at each byte position. The sequence of byte indices sent and the done or err outcome show whether the boundary between retrying and giving up sits exactly at byte 2*BUF_BYTES. Further patterns hold the channel busy before sending, stall the slot, and drive the grant line while ci_code says busy. They also repeat early collisions until the counter saturates, and issue start pulses while the gate is busy or with a length of zero. Each of these separates one gating or counting rule from the others.

// File: rtl/dchan_tx_gate.sv
module dchan_tx_gate #(
  parameter int LEN_W     = 6,
  parameter int BUF_BYTES = 4,
  parameter int RETRY_W   = 4,
  parameter int CI_W      = 6,
  parameter int FREE_BIT  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CI_W-1:0]    ci_code,
  input  logic               grant,
  input  logic               use_grant,
  input  logic               start,
  input  logic [LEN_W-1:0]   frame_len,
  input  logic               slot,
  input  logic [7:0]         rd_data,
  output logic [LEN_W-1:0]   rd_ptr,
  output logic               tx_en,
  output logic [7:0]         tx_byte,
  output logic               busy,
  output logic               done,
  output logic               err,
  output logic [RETRY_W-1:0] retries
);

  localparam logic [LEN_W:0]     RETRY_SPAN = (LEN_W+1)'(2 * BUF_BYTES);
  localparam logic [RETRY_W-1:0] RC_MAX     = '1;

  typedef enum logic [1:0] {IDLE, WAIT_FREE, SEND, ABORT} st_t;

  st_t              st;
  logic [LEN_W-1:0] len_q;
  logic             free, last, collide, early;

  assign free    = use_grant ? grant : ~ci_code[FREE_BIT];
  assign last    = (rd_ptr == len_q - 1'b1);
  assign early   = ({1'b0, rd_ptr} < RETRY_SPAN);
  assign collide = (st == SEND) && !free;
  assign tx_en   = (st == SEND) && free && slot;
  assign tx_byte = rd_data;
  assign busy    = (st != IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= IDLE;
      rd_ptr  <= '0;
      len_q   <= '0;
      retries <= '0;
      done    <= 1'b0;
      err     <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      case (st)
        IDLE:
          if (start && frame_len != '0) begin
            len_q  <= frame_len;
            rd_ptr <= '0;
            st     <= WAIT_FREE;
          end
        WAIT_FREE:
          if (free) st <= SEND;
        SEND:
          if (collide) begin
            rd_ptr <= '0;
            if (early) begin
              st <= ABORT;
              if (retries != RC_MAX) retries <= retries + 1'b1;
            end else begin
              err <= 1'b1;
              st  <= IDLE;
            end
          end else if (slot) begin
            if (last) begin
              done    <= 1'b1;
              retries <= '0;
              rd_ptr  <= '0;
              st      <= IDLE;
            end else begin
              rd_ptr <= rd_ptr + 1'b1;
            end
          end
        default:
          st <= WAIT_FREE;
      endcase
    end
  end

  AST_NO_TX_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    tx_en |-> free); // R2
  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && !last) |=> rd_ptr == LEN_W'($past(rd_ptr) + 1'b1)); // R3
  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (st == SEND && free && !slot) |=> $stable(rd_ptr)); // R3
  AST_ABORT_REWIND: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ABORT) |-> rd_ptr == '0); // R4
  AST_LATE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (collide && !early) |=> err && !busy); // R5
  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err)); // R5
  AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (retries == '0 && !busy)); // R6
  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (retries == RC_MAX) |=> (retries == RC_MAX || done)); // R9

endmodule

// File: tb/test_dchan_tx_gate.sv
module test_dchan_tx_gate;
  localparam int LEN_W = 5, BUFB = 2, RW = 2, SPAN = 2 * BUFB;

  logic clk = 0, rst_n = 0;
  logic [5:0] ci_code = 0;
  logic grant = 0, use_grant = 0, start = 0, slot = 1;
  logic [LEN_W-1:0] frame_len = 0;
  logic [7:0] rd_data, tx_byte, tag = 8'h10;
  logic [LEN_W-1:0] rd_ptr;
  logic tx_en, busy, done, err;
  logic [RW-1:0] retries;
  int n_cmp = 0, n_bad = 0;

  always #4 clk = ~clk;
  assign rd_data = 8'(rd_ptr * 7) + tag;

  dchan_tx_gate #(.LEN_W(LEN_W), .BUF_BYTES(BUFB), .RETRY_W(RW)) i_dchan_tx_gate (
    .clk(clk), .rst_n(rst_n), .ci_code(ci_code), .grant(grant), .use_grant(use_grant),
    .start(start), .frame_len(frame_len), .slot(slot), .rd_data(rd_data),
    .rd_ptr(rd_ptr), .tx_en(tx_en), .tx_byte(tx_byte), .busy(busy),
    .done(done), .err(err), .retries(retries));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic kick(input int len);
    @(negedge clk); frame_len = LEN_W'(len); start = 1;
    @(negedge clk); start = 0;
  endtask

  // one frame, single collision at byte p (p<0: none)
  task automatic run_frame(input int len, input int p);
    int exp_q[$], got_q[$];
    bit saw_done = 0, saw_err = 0;
    tag = tag + 8'd3;
    if (p >= 0) for (int k = 0; k < p; k++) exp_q.push_back(k);
    if (p < 0 || p < SPAN) for (int k = 0; k < len; k++) exp_q.push_back(k);
    kick(len);
    for (int cyc = 0; cyc < 80 && !saw_done && !saw_err; cyc++) begin
      ci_code = (p >= 0 && cyc == p + 1) ? 6'h10 : 6'h00;
      #2;
      if (done) saw_done = 1;
      if (err) saw_err = 1;
      if (tx_en) begin
        got_q.push_back(int'(rd_ptr));
        chk(tx_byte == 8'(rd_ptr * 7) + tag, "R3 byte", tx_byte, 8'(rd_ptr * 7) + tag);
      end
      if (p >= 0 && cyc == p + 1) chk(!tx_en, "R4 no tx on collision", tx_en, 0);
      if (p >= 0 && cyc == p + 2) begin
        if (p < SPAN) begin
          chk(rd_ptr == 0, "R4 rewind", rd_ptr, 0);
          chk(retries == 1, "R4 retry count", retries, 1);
        end else begin
          chk(err && !busy, "R5 late error", {err, busy}, 2);
        end
      end
      if (!saw_done && !saw_err) @(negedge clk);
    end
    ci_code = 0;
    chk(got_q.size() == exp_q.size(), "R3/R4/R5 byte count", got_q.size(), exp_q.size());
    foreach (exp_q[k])
      if (k < got_q.size()) chk(got_q[k] == exp_q[k], "R4 byte order", got_q[k], exp_q[k]);
    if (p >= SPAN) chk(saw_err && !saw_done, "R5 outcome", saw_err, 1);
    else begin
      chk(saw_done && !saw_err, "R6 outcome", saw_done, 1);
      chk(retries == 0 && !busy, "R6 retries cleared", retries, 0);
    end
  endtask

  initial begin
    #2000000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int cnt, coll;
    logic [LEN_W-1:0] hold;
    #1;
    chk(!busy && !tx_en && !done && !err && rd_ptr == 0 && retries == 0, "R1 reset", busy, 0);
    #20 rst_n = 1;
    @(negedge clk);
    chk(!busy && rd_ptr == 0 && retries == 0, "R1 after release", busy, 0);

    // main sweep, grant held low with use_grant=0 (R7: grant ignored)
    for (int len = 1; len <= 9; len++)
      for (int p = -1; p < len; p++) run_frame(len, p);

    // R2: held busy, then R3 slot stall
    ci_code = 6'h10;
    kick(5);
    for (int c = 0; c < 8; c++) begin
      #2; chk(!tx_en && busy && rd_ptr == 0, "R2 hold off", tx_en, 0);
      @(negedge clk);
    end
    ci_code = 6'h2f;  // other bits set, bit 4 clear: free
    @(negedge clk); @(negedge clk); @(negedge clk);
    slot = 0; #2; hold = rd_ptr;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk); #2;
      chk(!tx_en && rd_ptr == hold, "R3 slot stall", rd_ptr, hold);
    end
    slot = 1;
    cnt = 0;
    for (int c = 0; c < 20 && busy; c++) begin @(negedge clk); #2; end
    chk(!busy && retries == 0, "R6 after stall", busy, 0);
    ci_code = 0;

    // R7: grant mode, ci busy ignored
    use_grant = 1; ci_code = 6'h10; grant = 0;
    kick(3);
    for (int c = 0; c < 5; c++) begin
      #2; chk(!tx_en, "R7 grant low blocks", tx_en, 0);
      @(negedge clk);
    end
    grant = 1; cnt = 0;
    for (int c = 0; c < 10; c++) begin
      #2; if (tx_en) cnt++;
      if (done) break;
      @(negedge clk);
    end
    chk(cnt == 3 && done, "R7 grant frame", cnt, 3);
    use_grant = 0; ci_code = 0; grant = 0;

    // R8: start while busy and zero length
    kick(3);
    frame_len = 9; start = 1; @(negedge clk); start = 0;
    cnt = 0;
    for (int c = 0; c < 20; c++) begin
      #2; if (tx_en) cnt++;
      if (done) break;
      @(negedge clk);
    end
    chk(cnt == 3, "R8 start ignored while busy", cnt, 3);
    @(negedge clk); #2;
    chk(!busy, "R8 no restart", busy, 0);
    kick(0); #2;
    chk(!busy, "R8 zero length ignored", busy, 0);

    // R9: saturation then late error keeps value
    kick(8);
    coll = 0;
    for (int c = 0; c < 120; c++) begin
      ci_code = ((rd_ptr == 1 && coll < 5) || rd_ptr == 5) ? 6'h10 : 6'h00;
      if (rd_ptr == 1 && ci_code[4]) coll++;
      #2;
      if (err) break;
      @(negedge clk);
    end
    ci_code = 0;
    chk(coll == 5, "R9 collisions made", coll, 5);
    chk(retries == 3, "R9 saturated", retries, 3);
    chk(err && !busy, "R5 err after retries", err, 1);
    @(negedge clk); #2;
    chk(retries == 3 && !err, "R5 retries kept", retries, 3);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule